// File: doc/BRIEF.md
# Branch Resolution Unit

This unit resolves one branch per accepted transfer for a 32-bit RISC core whose bits are numbered from the most significant end. Each request carries a pre-decoded branch (form code, word-offset immediates, the 5-bit branch-option field, the condition-bit index, and the absolute and link flags), together with the current PC, the condition register, the count register and the link register. The unit registers one result: whether the branch is taken, the next PC, an optional decremented count with its write enable, and an optional link value with its write enable.

Requests enter on a valid/ready stream and results leave on a valid/ready stream through a single output register. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While a result is held with `out_ready` low, that result stays unchanged and no new request is taken. Form codes: 0 = unconditional immediate, 1 = conditional immediate, 2 = conditional to register, 3 = reserved. Within the option field, bit 4 bypasses the condition test, bit 3 is the wanted condition value, bit 2 bypasses the counter, and bit 1 selects the wanted counter outcome.

Top module: `br_resolve`

## Requirements
- R1: While reset is asserted and in the cycle after it, `out_valid` is 0; `in_ready` is 1 while the output register is empty.
- R2: A request accepted on an edge appears with `out_valid` = 1 after that edge. While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and every result output holds its value.
- R3: Form 0 forms its displacement as the 24-bit immediate shifted left by 2 and sign-extended from bit 25. The target is PC + displacement when the absolute flag is 0, or the displacement alone when it is 1. Form 0 is always taken.
- R4: Form 1 forms its displacement as the 14-bit immediate shifted left by 2 and sign-extended from bit 15, with the same absolute/relative rule as R3. It is taken only when both the counter test and the condition test pass.
- R5: Form 2 targets the link register (select 0) or the count value before any decrement (select 1), with bits 1:0 forced to 0. It is taken only when both tests pass.
- R6: With option bit 2 set, the counter test passes and `out_ctr_we` is 0.
- R7: For forms 1 and 2 with option bit 2 clear, `out_ctr` = count − 1 (wrapping, so 0 becomes FFFFFFFF) and `out_ctr_we` = 1 whether or not the branch is taken. The counter test passes when the new count is nonzero and option bit 1 is 0, or when it is zero and option bit 1 is 1.
- R8: With option bit 4 set, the condition test passes. Otherwise it passes when condition-register bit (31 − index), which is bit `index` counted from the MSB, equals option bit 3.
- R9: When a branch is not taken, `out_next_pc` = PC + 4.
- R10: For forms 0 to 2 with the link flag set, `out_lr_we` = 1 and `out_lr` = PC + 4, taken or not. With the link flag clear, `out_lr_we` = 0.
- R11: Form 0 ignores the option and index fields and never writes the count (`out_ctr_we` = 0).
- R12: Form 3 is not taken: `out_next_pc` = PC + 4, and both `out_ctr_we` and `out_lr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_form | input | 2 | Branch form code |
| in_li | input | 24 | Unconditional word offset |
| in_bd | input | 14 | Conditional word offset |
| in_bo | input | 5 | Branch option field |
| in_bi | input | 5 | Condition bit index, MSB-first |
| in_aa | input | 1 | Absolute target flag |
| in_lk | input | 1 | Link flag |
| in_reg_sel | input | 1 | Register target: 0 link, 1 count |
| in_pc | input | 32 | Address of the branch |
| in_cr | input | 32 | Condition register |
| in_ctr | input | 32 | Count register |
| in_lr | input | 32 | Link register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 32 | Next fetch address |
| out_ctr_we | output | 1 | Count write enable |
| out_ctr | output | 32 | New count value |
| out_lr_we | output | 1 | Link write enable |
| out_lr | output | 32 | New link value |

## Verification
The bench covers both sign-extension boundaries at the most negative and most positive offsets. A design that extends from the wrong bit produces a target in the wrong half of the address space. It runs every option-field value against counts of 0, 1 and 2. This catches a test made on the count before the decrement (wrong at 1), a wrap that saturates instead (wrong at 0), and an inverted sense of bit 1. Condition bits at index 0 and 31 expose LSB-first selection, and a register target with low bits set exposes missing alignment. A held result under back-pressure exposes an output that is overwritten or double-issued.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    BR_UNCOND   = 2'd0,
    BR_COND_IMM = 2'd1,
    BR_COND_REG = 2'd2,
    BR_RSVD     = 2'd3
  } br_form_e;

  localparam int BO_W         = 5;
  localparam int BO_CTR_ZERO  = 1;
  localparam int BO_CTR_SKIP  = 2;
  localparam int BO_COND_VAL  = 3;
  localparam int BO_COND_SKIP = 4;
endpackage

// File: rtl/br_disp_ext.sv
module br_disp_ext #(
  parameter int FIELD_W = 24,
  parameter int OUT_W   = 32
) (
  input  logic [FIELD_W-1:0] field,
  output logic [OUT_W-1:0]   disp
);
  localparam int SH_W = FIELD_W + 2;

  generate
    if (OUT_W > SH_W) begin : g_extend
      assign disp = {{(OUT_W-SH_W){field[FIELD_W-1]}}, field, 2'b00};
    end else begin : g_trunc
      logic [SH_W-1:0] shifted;
      assign shifted = {field, 2'b00};
      assign disp    = shifted[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import br_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LI_W = 24,
  parameter int BD_W = 14
) (
  input  logic [1:0]      form,
  input  logic [LI_W-1:0] li,
  input  logic [BD_W-1:0] bd,
  input  logic            aa,
  input  logic            reg_sel,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] ctr,
  input  logic [XLEN-1:0] lr,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] seq_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] disp_long, disp_short, imm, reg_src;

  br_disp_ext #(.FIELD_W(LI_W), .OUT_W(XLEN)) u_ext_long (
    .field(li), .disp(disp_long)
  );
  br_disp_ext #(.FIELD_W(BD_W), .OUT_W(XLEN)) u_ext_short (
    .field(bd), .disp(disp_short)
  );

  always_comb begin
    unique case (form)
      BR_UNCOND:   imm = disp_long;
      BR_COND_IMM: imm = disp_short;
      default:     imm = '0;
    endcase
  end

  assign reg_src = reg_sel ? ctr : lr;
  assign seq_pc  = pc + STEP;

  always_comb begin
    if (form == BR_COND_REG) target = {reg_src[XLEN-1:2], 2'b00};
    else if (aa)             target = imm;
    else                     target = pc + imm;
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int BI_W = $clog2(XLEN)
) (
  input  logic [BO_W-1:0] bo,
  input  logic [BI_W-1:0] bi,
  input  logic [XLEN-1:0] cr,
  input  logic [XLEN-1:0] ctr,
  output logic [XLEN-1:0] ctr_dec,
  output logic            dec_req,
  output logic            ctr_pass,
  output logic            cond_pass
);
  localparam logic [BI_W-1:0] TOP_IDX = BI_W'(XLEN - 1);

  logic [BI_W-1:0] cr_idx;
  logic            cr_bit, dec_zero;

  assign ctr_dec  = ctr - XLEN'(1);
  assign dec_zero = (ctr_dec == '0);
  assign dec_req  = ~bo[BO_CTR_SKIP];
  assign ctr_pass = bo[BO_CTR_SKIP] | (dec_zero == bo[BO_CTR_ZERO]);

  // condition bits are numbered from the MSB
  assign cr_idx    = TOP_IDX - bi;
  assign cr_bit    = cr[cr_idx];
  assign cond_pass = bo[BO_COND_SKIP] | (cr_bit == bo[BO_COND_VAL]);
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LI_W = 24,
  parameter int BD_W = 14,
  localparam int BI_W = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_form,
  input  logic [LI_W-1:0] in_li,
  input  logic [BD_W-1:0] in_bd,
  input  logic [4:0]      in_bo,
  input  logic [BI_W-1:0] in_bi,
  input  logic            in_aa,
  input  logic            in_lk,
  input  logic            in_reg_sel,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_cr,
  input  logic [XLEN-1:0] in_ctr,
  input  logic [XLEN-1:0] in_lr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_taken,
  output logic [XLEN-1:0] out_next_pc,
  output logic            out_ctr_we,
  output logic [XLEN-1:0] out_ctr,
  output logic            out_lr_we,
  output logic [XLEN-1:0] out_lr
);
  typedef struct packed {
    logic            taken;
    logic [XLEN-1:0] npc;
    logic            ctr_we;
    logic [XLEN-1:0] ctr;
    logic            lr_we;
    logic [XLEN-1:0] lr;
  } res_t;

  logic [XLEN-1:0] target, seq_pc, ctr_dec;
  logic            dec_req, ctr_pass, cond_pass, is_cond, accept;
  res_t            res_d, res_q;
  logic            valid_q;

  br_target_gen #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W)) u_tgt (
    .form(in_form), .li(in_li), .bd(in_bd), .aa(in_aa),
    .reg_sel(in_reg_sel), .pc(in_pc), .ctr(in_ctr), .lr(in_lr),
    .target(target), .seq_pc(seq_pc)
  );

  br_cond_eval #(.XLEN(XLEN), .BI_W(BI_W)) u_cond (
    .bo(in_bo), .bi(in_bi), .cr(in_cr), .ctr(in_ctr),
    .ctr_dec(ctr_dec), .dec_req(dec_req),
    .ctr_pass(ctr_pass), .cond_pass(cond_pass)
  );

  assign is_cond = (in_form == BR_COND_IMM) || (in_form == BR_COND_REG);

  always_comb begin
    res_d.taken  = (in_form == BR_UNCOND) || (is_cond && ctr_pass && cond_pass);
    res_d.npc    = res_d.taken ? target : seq_pc;
    res_d.ctr_we = is_cond && dec_req;
    res_d.ctr    = res_d.ctr_we ? ctr_dec : in_ctr;
    res_d.lr_we  = in_lk && (in_form != BR_RSVD);
    res_d.lr     = seq_pc;
  end

  assign in_ready = ~valid_q | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      if (accept) begin
        valid_q <= 1'b1;
        res_q   <= res_d;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_taken   = res_q.taken;
  assign out_next_pc = res_q.npc;
  assign out_ctr_we  = res_q.ctr_we;
  assign out_ctr     = res_q.ctr;
  assign out_lr_we   = res_q.lr_we;
  assign out_lr      = res_q.lr;
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_form,
  input logic [4:0]      in_bo,
  input logic            in_lk,
  input logic [XLEN-1:0] in_pc,
  input logic [XLEN-1:0] in_ctr,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_taken,
  input logic [XLEN-1:0] out_next_pc,
  input logic            out_ctr_we,
  input logic [XLEN-1:0] out_ctr,
  input logic            out_lr_we,
  input logic [XLEN-1:0] out_lr
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_RST_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_taken) && $stable(out_next_pc)
      && $stable(out_ctr) && $stable(out_lr)); // R2
  AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_form == 2'd0 |=> out_taken && !out_ctr_we); // R11
  AST_REG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_form == 2'd2 |=> !out_taken || out_next_pc[1:0] == 2'b00); // R5
  AST_CTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_bo[2] |=> !out_ctr_we); // R6
  AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_bo[2] && (in_form == 2'd1 || in_form == 2'd2)
      |=> out_ctr_we && out_ctr == $past(in_ctr) - XLEN'(1)); // R7
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_taken || out_next_pc == $past(in_pc) + XLEN'(4)); // R9
  AST_LINK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_lk && in_form != 2'd3 |=> out_lr_we && out_lr == $past(in_pc) + XLEN'(4)); // R10
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_form == 2'd3 |=> !out_taken && !out_ctr_we && !out_lr_we); // R12
endmodule

bind br_resolve br_resolve_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/br_resolve_tb.sv
`timescale 1ns/1ps
module br_resolve_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, out_ready = 1'b1;
  logic [1:0]  in_form = '0;
  logic [23:0] in_li = '0;
  logic [13:0] in_bd = '0;
  logic [4:0]  in_bo = '0, in_bi = '0;
  logic        in_aa = 1'b0, in_lk = 1'b0, in_reg_sel = 1'b0;
  logic [31:0] in_pc = '0, in_cr = '0, in_ctr = '0, in_lr = '0;
  logic        out_valid, out_taken, out_ctr_we, out_lr_we;
  logic [31:0] out_next_pc, out_ctr, out_lr;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  br_resolve u_dut (.*);

  typedef struct packed {
    logic [1:0]  form; logic [23:0] li; logic [13:0] bd; logic [4:0] bo; logic [4:0] bi;
    logic aa; logic lk; logic sel;
    logic [31:0] pc; logic [31:0] cr; logic [31:0] ctr; logic [31:0] lr;
    logic taken; logic [31:0] npc;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{2'd0, 24'h000001, 14'h0, 5'b00000, 5'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h10, 32'h0, 1'b1, 32'h00001004},
    '{2'd0, 24'hFFFFFF, 14'h0, 5'b00000, 5'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h10, 32'h0, 1'b1, 32'h00000FFC},
    '{2'd0, 24'h800000, 14'h0, 5'b00000, 5'd0, 1'b1, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h10, 32'h0, 1'b1, 32'hFE000000},
    '{2'd0, 24'h7FFFFF, 14'h0, 5'b00000, 5'd0, 1'b1, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h10, 32'h0, 1'b1, 32'h01FFFFFC},
    '{2'd1, 24'h0, 14'h2000, 5'b10100, 5'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h10, 32'h0, 1'b1, 32'hFFFF9000},
    '{2'd1, 24'h0, 14'h1FFF, 5'b10100, 5'd0, 1'b1, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h10, 32'h0, 1'b1, 32'h00007FFC},
    '{2'd1, 24'h0, 14'h0004, 5'b01100, 5'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h80000000, 32'h10, 32'h0, 1'b1, 32'h00001010},
    '{2'd1, 24'h0, 14'h0004, 5'b01100, 5'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h7FFFFFFF, 32'h10, 32'h0, 1'b0, 32'h00001004},
    '{2'd1, 24'h0, 14'h0004, 5'b00100, 5'd31, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h00000001, 32'h10, 32'h0, 1'b0, 32'h00001004},
    '{2'd1, 24'h0, 14'h0004, 5'b00100, 5'd31, 1'b0, 1'b0, 1'b0, 32'h1000, 32'hFFFFFFFE, 32'h10, 32'h0, 1'b1, 32'h00001010},
    '{2'd2, 24'h0, 14'h0, 5'b10100, 5'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h10, 32'h12345677, 1'b1, 32'h12345674},
    '{2'd2, 24'h0, 14'h0, 5'b10100, 5'd0, 1'b0, 1'b0, 1'b1, 32'h1000, 32'h0, 32'hABCDEF03, 32'h0, 1'b1, 32'hABCDEF00},
    '{2'd3, 24'h000010, 14'h0, 5'b10100, 5'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h10, 32'h0, 1'b0, 32'h00001004}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic void ref_eval(
    input logic [1:0] f, input logic [23:0] li, input logic [13:0] bd,
    input logic [4:0] bo, input logic [4:0] bi, input logic aa, input logic lk, input logic sel,
    input logic [31:0] pc, input logic [31:0] cr, input logic [31:0] ctr, input logic [31:0] lr,
    output logic tk, output logic [31:0] npc, output logic cwe, output logic [31:0] cnew,
    output logic lwe, output logic [31:0] lnew);
    logic [31:0] d, tgt, nc;
    logic cok, qok;
    cwe = 1'b0; cnew = ctr; tk = 1'b0; tgt = 32'h0;
    if (f == 2'd0) begin
      d = {8'h0, li} << 2;
      if (d & 32'h02000000) d = d | 32'hFC000000;
      tgt = aa ? d : pc + d; tk = 1'b1;
    end else if (f == 2'd1 || f == 2'd2) begin
      cok = 1'b1;
      if (!bo[2]) begin
        nc = ctr - 32'd1; cwe = 1'b1; cnew = nc;
        cok = (nc != 0) ? !bo[1] : bo[1];
      end
      qok = bo[4] ? 1'b1 : (((cr >> (31 - bi)) & 32'd1) == {31'd0, bo[3]});
      tk = cok && qok;
      if (f == 2'd1) begin
        d = {18'h0, bd} << 2;
        if (d & 32'h00008000) d = d | 32'hFFFF0000;
        tgt = aa ? d : pc + d;
      end else begin
        tgt = (sel ? ctr : lr) & 32'hFFFFFFFC;
      end
    end
    npc  = tk ? tgt : pc + 32'd4;
    lwe  = lk && (f != 2'd3);
    lnew = pc + 32'd4;
  endfunction

  task automatic drive(input vec_t v);
    in_form = v.form; in_li = v.li; in_bd = v.bd; in_bo = v.bo; in_bi = v.bi;
    in_aa = v.aa; in_lk = v.lk; in_reg_sel = v.sel;
    in_pc = v.pc; in_cr = v.cr; in_ctr = v.ctr; in_lr = v.lr;
  endtask

  // drive on falling edge, accept on rising edge, sample on next falling edge
  task automatic issue(input vec_t v);
    @(negedge clk);
    drive(v); in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t v;
    logic tk, cwe, lwe;
    logic [31:0] npc, cn, ln;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

    // R3 R4 R5 R8 R9 R12: table walk
    for (int i = 0; i < NV; i++) begin
      issue(VT[i]);
      chk($sformatf("R2 valid vec%0d", i), {31'd0, out_valid}, 32'd1);
      chk($sformatf("R3/R4/R5/R8/R12 taken vec%0d", i), {31'd0, out_taken}, {31'd0, VT[i].taken});
      chk($sformatf("R3/R4/R5/R9 npc vec%0d", i), out_next_pc, VT[i].npc);
      chk($sformatf("R6/R11 ctr_we vec%0d", i), {31'd0, out_ctr_we}, 32'd0);
    end

    // R6 R7 R8 R10: every option value against counts 0, 1, 2
    for (int b = 0; b < 32; b++) begin
      for (int c = 0; c < 3; c++) begin
        v = '0;
        v.form = (c == 2) ? 2'd2 : 2'd1;
        v.bd = 14'h0008; v.bo = 5'(b); v.bi = 5'((b * 7 + c * 13) % 32);
        v.lk = b[0] ^ c[0]; v.sel = b[1];
        v.pc = 32'h0000_4000 + 32'(b * 64); v.cr = 32'hA5C3_0F96 ^ 32'(c * 32'h1111_0000);
        v.ctr = 32'(c); v.lr = 32'h0000_8003;
        issue(v);
        ref_eval(v.form, v.li, v.bd, v.bo, v.bi, v.aa, v.lk, v.sel, v.pc, v.cr, v.ctr, v.lr,
                 tk, npc, cwe, cn, lwe, ln);
        chk($sformatf("R7/R8 taken bo=%0d ctr=%0d", b, c), {31'd0, out_taken}, {31'd0, tk});
        chk($sformatf("R4/R5/R9 npc bo=%0d ctr=%0d", b, c), out_next_pc, npc);
        chk($sformatf("R6/R7 ctr_we bo=%0d ctr=%0d", b, c), {31'd0, out_ctr_we}, {31'd0, cwe});
        if (cwe) chk($sformatf("R7 ctr bo=%0d ctr=%0d", b, c), out_ctr, cn);
        chk($sformatf("R10 lr_we bo=%0d ctr=%0d", b, c), {31'd0, out_lr_we}, {31'd0, lwe});
        if (lwe) chk($sformatf("R10 lr bo=%0d ctr=%0d", b, c), out_lr, ln);
      end
    end

    // R7: wrap from zero, branch on nonzero count
    v = '0; v.form = 2'd1; v.bo = 5'b10000; v.bd = 14'h0010; v.pc = 32'h2000; v.ctr = 32'h0;
    issue(v);
    chk("R7 wrap value", out_ctr, 32'hFFFF_FFFF);
    chk("R7 wrap taken", {31'd0, out_taken}, 32'd1);
    chk("R7 wrap target", out_next_pc, 32'h2040);

    // R7: one to zero, branch on nonzero count, not taken but still written
    v.ctr = 32'h1;
    issue(v);
    chk("R7 one-to-zero not taken", {31'd0, out_taken}, 32'd0);
    chk("R7 one-to-zero write", {31'd0, out_ctr_we}, 32'd1);
    chk("R7 one-to-zero value", out_ctr, 32'h0);

    // R10: link written on not-taken branch
    v = '0; v.form = 2'd1; v.bo = 5'b00100; v.bi = 5'd0; v.cr = 32'h8000_0000; v.lk = 1'b1;
    v.pc = 32'h3000;
    issue(v);
    chk("R10 not-taken link we", {31'd0, out_lr_we}, 32'd1);
    chk("R10 not-taken link value", out_lr, 32'h3004);
    chk("R9 not-taken npc", out_next_pc, 32'h3004);

    // R12: reserved form with link flag set
    v.form = 2'd3;
    issue(v);
    chk("R12 reserved no link", {31'd0, out_lr_we}, 32'd0);

    // R2: back-pressure
    @(negedge clk);
    v = '0; v.form = 2'd0; v.li = 24'h1; v.pc = 32'h1000;
    drive(v); in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk("R2 held valid", {31'd0, out_valid}, 32'd1);
    chk("R2 ready low", {31'd0, in_ready}, 32'd0);
    chk("R2 first result", out_next_pc, 32'h1004);
    v.li = 24'h2; drive(v);
    @(negedge clk);
    chk("R2 result held", out_next_pc, 32'h1004);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 second result", out_next_pc, 32'h1008);
    @(negedge clk);
    chk("R2 drained", {31'd0, out_valid}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule